// File: doc/BRIEF.md
# Period-Reciprocal Square-Wave Synthesizer

This block turns the frequency of an asynchronous input signal into an output square wave whose frequency is a programmable multiple of it. An up-counter, advanced by a first count-enable strobe, measures how many strobes fall between successive rising edges of the input. The finished count is latched into a holding register. It is then scaled by a binary shift in either direction, a constant correction is added, and the result is halved. A down-counter, advanced by a second count-enable strobe, reloads from that value and toggles the output each time it expires. The output frequency is therefore the second strobe rate divided by the scaled count, and it follows the input as the input changes.

With both strobes at the same rate and no shift, the output has the input's frequency. A right shift by k multiplies the output frequency by 2^k. A left shift divides it by 2^k. The correction input cancels the small, nearly fixed count that the load/clear sequence loses. An input period longer than the counter can hold is flagged and thrown away.

Top module: `freq_synth_ctr`

## Requirements
- R1: After reset, `sq_out`, `ovf_flag` and `period_valid` are 0. `sq_out` stays 0 for as long as `period_valid` is 0.
- R2: The raw input passes through a two-stage synchronizer. The first rising edge only starts a measurement. Each later rising edge latches the number of `meas_tick` strobes since the edge before it. `period_valid` goes to 1 at the first such latch and is still 0 after only one rising edge.
- R3: Every high phase and every low phase of `sq_out` lasts P `gen_tick` strobes, where P is the preset defined in R4–R7. This gives a 50% duty cycle.
- R4: With `shift_dir`=0, the latched count N is shifted right by `shift_amt` bits.
- R5: With `shift_dir`=1, N is shifted left by `shift_amt` bits.
- R6: `ofs_corr` is added to the shifted count, and the sum is halved to give P.
- R7: P is never less than 2.
- R8: If a `meas_tick` strobe arrives while the measure count is all ones, `ovf_flag` is set and stays set until reset. The count saturates, and the period in progress is discarded, so the latched value keeps its previous contents.
- R9: The output counter advances only on `gen_tick`. Halving the `gen_tick` rate doubles every phase length in clocks.
- R10: The measure counter advances only on `meas_tick`. Halving the `meas_tick` rate halves N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_tick | input | 1 | Count enable for the period measurement |
| gen_tick | input | 1 | Count enable for the output counter |
| sig_in | input | 1 | Raw asynchronous input signal |
| shift_dir | input | 1 | 0: shift right (output faster), 1: shift left (output slower) |
| shift_amt | input | SHIFT_W | Shift distance in bits |
| ofs_corr | input | OFS_W | Count added before halving |
| sq_out | output | 1 | Square-wave output |
| ovf_flag | output | 1 | Sticky measurement overflow flag |
| period_valid | output | 1 | A complete period has been latched |

## Verification
A rising edge on the input becomes a period boundary in the clock domain two cycles later, and the count is latched on the next edge. A new preset takes effect only at the next expiry of the output counter. For this reason the bench never times a single edge. It waits at least three input periods and several output phases after each change of input rate, strobe rate or control. It then samples `sq_out` on falling clock edges and counts the cycles of one complete high or low phase. That count equals P times the `gen_tick` divisor, whatever the latency. Flags are read on a falling edge well after the event that sets them. The check that `period_valid` is still 0 is taken halfway between the first and second input rises.

// File: rtl/fsyn_pkg.sv
package fsyn_pkg;

   typedef enum logic {
      SHIFT_DIVIDE   = 1'b0,
      SHIFT_MULTIPLY = 1'b1
   } shift_dir_e;

   localparam int FSYN_MIN_PRESET = 2;

endpackage

// File: rtl/fsyn_edge_sync.sv
module fsyn_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fsyn_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chain_q[i] <= 1'b0;
            end else if (i == 0) begin
               chain_q[i] <= din;
            end else begin
               chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= 1'b0;
      end else begin
         last_q <= chain_q[STAGES-1];
      end
   end

   assign rise = chain_q[STAGES-1] & ~last_q;

   // R2: a boundary pulse lasts one cycle only
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/fsyn_period_meter.sv
module fsyn_period_meter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             boundary,
   output logic [CNT_W-1:0] period_cnt,
   output logic             valid,
   output logic             ovf
);

   localparam logic [CNT_W-1:0] CNT_FULL = {CNT_W{1'b1}};

   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] hold_q;
   logic             armed_q;
   logic             spoiled_q;
   logic             valid_q;
   logic             ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q     <= '0;
         hold_q    <= '0;
         armed_q   <= 1'b0;
         spoiled_q <= 1'b0;
         valid_q   <= 1'b0;
         ovf_q     <= 1'b0;
      end else if (boundary) begin
         if (armed_q && !spoiled_q) begin
            hold_q  <= run_q;
            valid_q <= 1'b1;
         end
         armed_q   <= 1'b1;
         spoiled_q <= 1'b0;
         run_q     <= CNT_W'(tick);
      end else if (tick && armed_q) begin
         if (run_q == CNT_FULL) begin
            spoiled_q <= 1'b1;
            ovf_q     <= 1'b1;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   assign period_cnt = hold_q;
   assign valid      = valid_q;
   assign ovf        = ovf_q;

   // R8: overflow flag is sticky
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);

   // R8: a discarded period leaves the latched value unchanged
   a_r8_hold_on_spoil: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && spoiled_q) |=> $stable(hold_q));

   // R10: without a strobe or boundary the count does not move
   a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !boundary) |=> $stable(run_q));

endmodule

// File: rtl/fsyn_scaler.sv
module fsyn_scaler
   import fsyn_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int SHIFT_W    = 4,
   parameter int OFS_W      = 8,
   parameter bit ALLOW_LEFT = 1'b1
) (
   input  logic [CNT_W-1:0]   count_in,
   input  shift_dir_e         dir,
   input  logic [SHIFT_W-1:0] amt,
   input  logic [OFS_W-1:0]   ofs,
   output logic [CNT_W-1:0]   preset
);

   localparam int MAX_SH = (1 << SHIFT_W) - 1;
   localparam int EXT_W  = CNT_W + MAX_SH;
   localparam logic [CNT_W-1:0] FULL  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] FLOOR = CNT_W'(FSYN_MIN_PRESET);

   logic [CNT_W-1:0] shifted;
   logic [CNT_W:0]   sum;
   logic [CNT_W-1:0] sum_sat;
   logic [CNT_W-1:0] half;

   generate
      if (OFS_W > CNT_W) begin : g_bad_ofs
         $error("fsyn_scaler: OFS_W must not exceed CNT_W");
      end
      if (ALLOW_LEFT) begin : g_bidir
         logic [EXT_W-1:0] wide;
         always_comb begin
            wide = EXT_W'(count_in) << amt;
            if (dir == SHIFT_MULTIPLY) begin
               shifted = (|wide[EXT_W-1:CNT_W]) ? FULL : wide[CNT_W-1:0];
            end else begin
               shifted = count_in >> amt;
            end
         end
      end else begin : g_right_only
         always_comb begin
            shifted = count_in >> amt;
         end
      end
   endgenerate

   always_comb begin
      sum     = {1'b0, shifted} + (CNT_W+1)'(ofs);
      sum_sat = sum[CNT_W] ? FULL : sum[CNT_W-1:0];
      half    = sum_sat >> 1;
      preset  = (half < FLOOR) ? FLOOR : half;
   end

endmodule

// File: rtl/fsyn_tone_gen.sv
module fsyn_tone_gen #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic [CNT_W-1:0] preset,
   output logic             wave
);

   logic [CNT_W-1:0] down_q;
   logic             wave_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         down_q <= '0;
         wave_q <= 1'b0;
      end else if (!en) begin
         down_q <= preset;
         wave_q <= 1'b0;
      end else if (tick) begin
         if (down_q <= CNT_W'(1)) begin
            wave_q <= ~wave_q;
            down_q <= preset;
         end else begin
            down_q <= down_q - 1'b1;
         end
      end
   end

   assign wave = wave_q;

   // R3: the running counter never sits at zero
   a_r3_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (down_q != '0));

   // R9: no strobe, no change of the output
   a_r9_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && !tick) |=> $stable(wave_q));

endmodule

// File: rtl/freq_synth_ctr.sv
module freq_synth_ctr
   import fsyn_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SHIFT_W     = 4,
   parameter int OFS_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit ALLOW_LEFT  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               meas_tick,
   input  logic               gen_tick,
   input  logic               sig_in,
   input  logic               shift_dir,
   input  logic [SHIFT_W-1:0] shift_amt,
   input  logic [OFS_W-1:0]   ofs_corr,
   output logic               sq_out,
   output logic               ovf_flag,
   output logic               period_valid
);

   generate
      if (CNT_W < 4) begin : g_bad_width
         $error("freq_synth_ctr: CNT_W must be at least 4");
      end
      if (SHIFT_W < 1 || SHIFT_W > 5) begin : g_bad_shift
         $error("freq_synth_ctr: SHIFT_W must be 1..5");
      end
   endgenerate

   logic             edge_rise;
   logic [CNT_W-1:0] held_count;
   logic [CNT_W-1:0] reload_val;
   logic             valid_w;

   fsyn_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sig_in),
      .rise (edge_rise)
   );

   fsyn_period_meter #(.CNT_W(CNT_W)) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (meas_tick),
      .boundary  (edge_rise),
      .period_cnt(held_count),
      .valid     (valid_w),
      .ovf       (ovf_flag)
   );

   fsyn_scaler #(
      .CNT_W     (CNT_W),
      .SHIFT_W   (SHIFT_W),
      .OFS_W     (OFS_W),
      .ALLOW_LEFT(ALLOW_LEFT)
   ) u_scale (
      .count_in(held_count),
      .dir     (shift_dir_e'(shift_dir)),
      .amt     (shift_amt),
      .ofs     (ofs_corr),
      .preset  (reload_val)
   );

   fsyn_tone_gen #(.CNT_W(CNT_W)) u_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (valid_w),
      .tick  (gen_tick),
      .preset(reload_val),
      .wave  (sq_out)
   );

   assign period_valid = valid_w;

   // R1: output idles low until a period is known
   a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !period_valid |-> !sq_out);

   // R7: the reload value respects the floor
   a_r7_preset_floor: assert property (@(posedge clk) disable iff (!rst_n)
      period_valid |-> (reload_val >= CNT_W'(FSYN_MIN_PRESET)));

   // R2: once valid, stays valid
   a_r2_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      period_valid |=> period_valid);

endmodule

// File: tb/tb_freq_synth_ctr.sv
module tb_freq_synth_ctr;

   localparam int SHIFT_W = 4;
   localparam int OFS_W   = 8;
   localparam int LIMIT   = 100000;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               meas_tick = 1'b0;
   logic               gen_tick = 1'b0;
   logic               sig_in = 1'b0;
   logic               shift_dir = 1'b0;
   logic [SHIFT_W-1:0] shift_amt = '0;
   logic [OFS_W-1:0]   ofs_corr = '0;
   logic               sq_out;
   logic               ovf_flag;
   logic               period_valid;

   int checks = 0;
   int fails  = 0;
   int sig_half = 50;
   bit sig_run  = 1'b0;
   int meas_div = 1;
   int gen_div  = 1;

   freq_synth_ctr dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .meas_tick   (meas_tick),
      .gen_tick    (gen_tick),
      .sig_in      (sig_in),
      .shift_dir   (shift_dir),
      .shift_amt   (shift_amt),
      .ofs_corr    (ofs_corr),
      .sq_out      (sq_out),
      .ovf_flag    (ovf_flag),
      .period_valid(period_valid)
   );

   always #2.5 clk = ~clk;

   // strobe generators
   initial begin
      int mc = 0;
      int gc = 0;
      forever begin
         @(posedge clk);
         mc = (mc + 1) % meas_div;
         gc = (gc + 1) % gen_div;
         meas_tick <= (mc == 0);
         gen_tick  <= (gc == 0);
      end
   end

   // input signal source
   initial begin
      int sc = 0;
      forever begin
         @(posedge clk);
         if (sig_run) begin
            sc++;
            if (sc >= sig_half) begin
               sig_in <= ~sig_in;
               sc = 0;
            end
         end
      end
   end

   task automatic check_eq(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_preset(int n, bit dir, int amt, int ofs);
      int s;
      int h;
      s = dir ? (n << amt) : (n >> amt);
      if (s > 65535) s = 65535;
      s = s + ofs;
      if (s > 65535) s = 65535;
      h = s / 2;
      return (h < 2) ? 2 : h;
   endfunction

   task automatic phase_len(input bit level, output int n);
      int guard = 0;
      n = 0;
      while (sq_out !== level && guard < LIMIT) begin @(negedge clk); guard++; end
      while (sq_out === level && guard < LIMIT) begin @(negedge clk); guard++; end
      while (sq_out !== level && guard < LIMIT) begin @(negedge clk); guard++; end
      while (sq_out === level && guard < LIMIT) begin n++; @(negedge clk); guard++; end
   endtask

   task automatic settle(int p);
      repeat (3 * 2 * sig_half * meas_div + 6 * p * gen_div + 40) @(negedge clk);
   endtask

   task automatic run_case(string req, string what, int half, int mdiv, int gdiv,
                           bit dir, int amt, int ofs);
      int p;
      int hi;
      int lo;
      sig_half  = half;
      meas_div  = mdiv;
      gen_div   = gdiv;
      shift_dir = dir;
      shift_amt = SHIFT_W'(amt);
      ofs_corr  = OFS_W'(ofs);
      p = exp_preset((2 * half) / mdiv, dir, amt, ofs);
      settle(p);
      phase_len(1'b1, hi);
      check_eq(req, {what, " high phase"}, hi, p * gdiv);
      phase_len(1'b0, lo);
      check_eq(req, {what, " low phase"}, lo, p * gdiv);
   endtask

   task automatic t_reset();
      repeat (4) @(negedge clk);
      check_eq("R1", "sq_out after reset", int'(sq_out), 0);
      check_eq("R1", "ovf_flag after reset", int'(ovf_flag), 0);
      check_eq("R1", "period_valid after reset", int'(period_valid), 0);
   endtask

   task automatic t_first_edge();
      sig_half = 50;
      sig_run  = 1'b1;
      repeat (100) @(negedge clk);
      check_eq("R2", "valid after one rising edge", int'(period_valid), 0);
      check_eq("R1", "sq_out while not valid", int'(sq_out), 0);
      repeat (200) @(negedge clk);
      check_eq("R2", "valid after two rising edges", int'(period_valid), 1);
   endtask

   task automatic t_overflow();
      int hi;
      run_case("R8", "baseline before stall", 50, 1, 1, 1'b0, 0, 0);
      sig_run = 1'b0;
      repeat (66000) @(negedge clk);
      check_eq("R8", "ovf_flag after long stall", int'(ovf_flag), 1);
      phase_len(1'b1, hi);
      check_eq("R8", "held period kept during stall", hi, 50);
      sig_half = 30;
      sig_run  = 1'b1;
      repeat (800) @(negedge clk);
      phase_len(1'b1, hi);
      check_eq("R8", "new period after recovery", hi, 30);
      check_eq("R8", "ovf_flag stays set", int'(ovf_flag), 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_first_edge();
      run_case("R3", "equal rates no shift", 50, 1, 1, 1'b0, 0, 0);
      run_case("R4", "right shift by 1", 50, 1, 1, 1'b0, 1, 0);
      run_case("R4", "right shift by 3", 80, 1, 1, 1'b0, 3, 0);
      run_case("R5", "left shift by 1", 50, 1, 1, 1'b1, 1, 0);
      run_case("R6", "offset 20", 50, 1, 1, 1'b0, 0, 20);
      run_case("R7", "floor on tiny count", 2, 1, 1, 1'b0, 2, 0);
      run_case("R9", "gen strobe every 2nd clock", 50, 1, 2, 1'b0, 0, 0);
      run_case("R10", "meas strobe every 2nd clock", 50, 2, 1, 1'b0, 0, 0);
      t_overflow();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule